// File: doc/BRIEF.md
# Indexed Jump-Table Branch Unit

This unit performs a branch whose target comes from a table in memory. The caller supplies an 8-bit table index, the address and byte size of the current instruction, and the value of the table base register. The unit clears the low mode bits of the base and adds the index scaled by the 8-byte entry size. It fetches that single 64-bit entry over a request/acknowledge memory port and then presents the fetched word as the new program counter.

The index range selects the form of the branch. An index below 32 gives a plain jump. An index of 32 or more gives a linking jump, which also writes the return address (current instruction address plus its size) to register x1. Results appear as a one-cycle strobe, and only after the memory read has been acknowledged. The unit takes one operation at a time and raises `busy` until that operation's result has been issued.

Top module: `jtab_branch_unit`

## Requirements
- R1: After reset, `busy`, `mem_req`, `pc_valid` and `link_we` are all 0.
- R2: The table read address equals the base with its low 6 bits forced to zero, plus the index times 8. The low 6 bits of the base have no effect on the address.
- R3: Once raised, `mem_req` stays high with an unchanged `mem_addr` until the cycle in which `mem_ack` is sampled high. In the cycle after that, `mem_req` is low.
- R4: `pc_valid` is high for exactly one cycle, the cycle after the acknowledged read. In that cycle `pc_target` equals the `mem_rdata` value sampled with the acknowledge.
- R5: An index in 0..31 produces `link_we` = 0 during the result strobe.
- R6: An index in 32..255 produces `link_we` = 1 together with `pc_valid`, with `link_addr` = 1 and `link_data` equal to the accepted instruction address plus the accepted size.
- R7: `busy` is high from the cycle after acceptance until the result strobe ends. A `req_valid` raised while `busy` is high is ignored and changes neither the pending read nor the result.
- R8: `pc_valid` and `link_we` never go high except in the cycle after an acknowledged read.
- R9: Operands are captured at acceptance. Changes to `req_index`, `req_pc`, `req_size` or `base_reg` after acceptance do not alter the address, target or link data of the operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start an operation (taken when `busy` is low) |
| req_index | input | 8 | Table index; 32 and above selects the linking form |
| req_pc | input | 64 | Address of the current instruction |
| req_size | input | 3 | Byte size of the current instruction |
| base_reg | input | 64 | Table base register, low 6 bits are mode bits |
| busy | output | 1 | Operation in flight, new requests refused |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 64 | Table entry byte address |
| mem_ack | input | 1 | Read acknowledge, `mem_rdata` valid with it |
| mem_rdata | input | 64 | Table entry value |
| pc_valid | output | 1 | One-cycle strobe for the new PC |
| pc_target | output | 64 | New program counter |
| link_we | output | 1 | One-cycle write strobe for the link register |
| link_addr | output | 5 | Link register number (always 1) |
| link_data | output | 64 | Return address |

## Verification
The checker assumes that the memory side raises `mem_ack` only while `mem_req` is high, and that `rst` is held for at least one clock before any request. The bench's memory model acknowledges only while it sees a pending request, after a chosen number of wait cycles. It drives `req_valid` only with known-good operands, and it deliberately raises `req_valid` during a pending read to exercise the refusal path. Return addresses are kept far from the 64-bit wrap, so the expected sum needs no modular reasoning.

// File: rtl/jtab_pkg.sv
package jtab_pkg;
    localparam int XLEN        = 64;
    localparam int IDX_W       = 8;
    localparam int SIZE_W      = 3;
    localparam int ENTRY_BYTES = 8;
    localparam int MODE_BITS   = 6;
    localparam int LINK_FIRST  = 32;
    localparam int REG_W       = 5;
    localparam int LINK_REG    = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic [XLEN-1:0] addr;
        logic            link;
        logic [XLEN-1:0] ret;
    } op_ctx_t;

    function automatic logic [XLEN-1:0] entry_addr(
        input logic [XLEN-1:0]  base,
        input logic [IDX_W-1:0] idx
    );
        logic [XLEN-1:0] aligned;
        logic [XLEN-1:0] offs;
        aligned = base & ~((XLEN'(1) << MODE_BITS) - XLEN'(1));
        offs    = XLEN'(idx) << $clog2(ENTRY_BYTES);
        return aligned + offs;
    endfunction

    function automatic logic wants_link(input logic [IDX_W-1:0] idx);
        return (32'(idx) >= LINK_FIRST);
    endfunction
endpackage

// File: rtl/jtab_addr_gen.sv
module jtab_addr_gen
    import jtab_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int IW = IDX_W,
    parameter int SW = SIZE_W
) (
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] index,
    input  logic [AW-1:0] pc,
    input  logic [SW-1:0] size,
    output op_ctx_t       ctx
);
    always_comb begin
        ctx.addr = entry_addr(base, index);
        ctx.link = wants_link(index);
        ctx.ret  = pc + AW'(size);
    end
endmodule

// File: rtl/jtab_ctrl.sv
module jtab_ctrl
    import jtab_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic ack,
    output logic accept,
    output logic reading,
    output logic done,
    output logic busy
);
    ctl_state_e st_q, st_d;

    assign accept  = start && (st_q == ST_IDLE);
    assign reading = (st_q == ST_WAIT);
    assign done    = (st_q == ST_DONE);
    assign busy    = (st_q != ST_IDLE);

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (start) st_d = ST_WAIT;
            ST_WAIT: if (ack)   st_d = ST_DONE;
            ST_DONE:            st_d = ST_IDLE;
            default:            st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/jtab_result.sv
module jtab_result
    import jtab_pkg::*;
#(
    parameter int AW = XLEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  op_ctx_t       ctx_in,
    input  logic          take_data,
    input  logic [AW-1:0] rdata,
    output op_ctx_t       ctx_q,
    output logic [AW-1:0] target_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q    <= '0;
            target_q <= '0;
        end else begin
            if (accept)    ctx_q    <= ctx_in;
            if (take_data) target_q <= rdata;
        end
    end
endmodule

// File: rtl/jtab_branch_unit.sv
module jtab_branch_unit
    import jtab_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int IW = IDX_W,
    parameter int SW = SIZE_W,
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [IW-1:0] req_index,
    input  logic [AW-1:0] req_pc,
    input  logic [SW-1:0] req_size,
    input  logic [AW-1:0] base_reg,
    output logic          busy,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata,
    output logic          pc_valid,
    output logic [AW-1:0] pc_target,
    output logic          link_we,
    output logic [RW-1:0] link_addr,
    output logic [AW-1:0] link_data
);
    op_ctx_t ctx_new, ctx_q;
    logic    accept, reading, done;

    jtab_addr_gen #(.AW(AW), .IW(IW), .SW(SW)) u_agen (
        .base (base_reg),
        .index(req_index),
        .pc   (req_pc),
        .size (req_size),
        .ctx  (ctx_new)
    );

    jtab_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (req_valid),
        .ack    (mem_ack),
        .accept (accept),
        .reading(reading),
        .done   (done),
        .busy   (busy)
    );

    jtab_result #(.AW(AW)) u_res (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .ctx_in   (ctx_new),
        .take_data(reading && mem_ack),
        .rdata    (mem_rdata),
        .ctx_q    (ctx_q),
        .target_q (pc_target)
    );

    assign mem_req   = reading;
    assign mem_addr  = ctx_q.addr;
    assign pc_valid  = done;
    assign link_we   = done && ctx_q.link;
    assign link_addr = RW'(LINK_REG);
    assign link_data = ctx_q.ret;
endmodule

// File: rtl/jtab_checker.sv
module jtab_checker #(
    parameter int AW = 64,
    parameter int RW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          pc_valid,
    input logic          link_we,
    input logic [RW-1:0] link_addr
);
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    assert_req_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> !mem_req);
    assert_strobe_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> pc_valid);
    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
        pc_valid |=> !pc_valid);
    assert_link_with_pc_R6: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (pc_valid && link_addr == RW'(1)));
    assert_busy_cover_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req || pc_valid) |-> busy);
    assert_no_early_update_R8: assert property (@(posedge clk) disable iff (rst)
        pc_valid |-> $past(mem_req && mem_ack));
endmodule

bind jtab_branch_unit jtab_checker #(.AW(AW), .RW(RW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .pc_valid (pc_valid),
    .link_we  (link_we),
    .link_addr(link_addr)
);

// File: tb/sim_jtab_branch_unit.sv
module sim_jtab_branch_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [7:0]  req_index;
    logic [63:0] req_pc;
    logic [2:0]  req_size;
    logic [63:0] base_reg;
    logic        busy, mem_req, mem_ack, pc_valid, link_we;
    logic [63:0] mem_addr, mem_rdata, pc_target, link_data;
    logic [4:0]  link_addr;

    int vectors = 0;
    int misses  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    jtab_branch_unit u0 (.*);

    function automatic logic [63:0] table_word(input logic [63:0] a);
        return {a[31:0] ^ 32'h5A5A_0000, ~a[31:0]};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One full operation; 'waits' cycles before ack; 'noise' drives extra requests
    // and changes operands while the read is pending.
    task automatic run_op(input logic [7:0] idx, input logic [63:0] pc,
                          input logic [2:0] sz, input logic [63:0] base,
                          input int waits, input bit noise);
        logic [63:0] exp_addr, exp_ret;
        exp_addr = (base & ~64'h3F) + {53'd0, idx, 3'b000};
        exp_ret  = pc + {61'd0, sz};
        @(negedge clk);
        req_valid = 1'b1; req_index = idx; req_pc = pc; req_size = sz; base_reg = base;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 busy after accept", {63'd0, busy}, 64'd1);
        chk("R2 mem_req", {63'd0, mem_req}, 64'd1);
        chk("R2 address", mem_addr, exp_addr);
        for (int w = 0; w < waits; w++) begin
            if (noise) begin
                req_valid = 1'b1; req_index = ~idx; req_pc = ~pc;
                req_size = ~sz; base_reg = ~base;
            end
            @(negedge clk);
            chk("R3 req held", {63'd0, mem_req}, 64'd1);
            chk("R9/R7 address stable", mem_addr, exp_addr);
            chk("R8 no early pc", {63'd0, pc_valid}, 64'd0);
        end
        mem_ack = 1'b1; mem_rdata = table_word(mem_addr);
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = '0;
        chk("R4 pc_valid", {63'd0, pc_valid}, 64'd1);
        chk("R4 target", pc_target, table_word(exp_addr));
        chk("R3 req dropped", {63'd0, mem_req}, 64'd0);
        if (idx >= 8'd32) begin
            chk("R6 link_we", {63'd0, link_we}, 64'd1);
            chk("R6 link_addr", {59'd0, link_addr}, 64'd1);
            chk("R6/R9 link_data", link_data, exp_ret);
        end else begin
            chk("R5 no link", {63'd0, link_we}, 64'd0);
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk("R4 strobe ends", {63'd0, pc_valid}, 64'd0);
        chk("R8 link ends", {63'd0, link_we}, 64'd0);
        chk("R7 idle again", {63'd0, busy}, 64'd0);
        chk("R7 no extra read", {63'd0, mem_req}, 64'd0);
    endtask

    task automatic test_reset();
        chk("R1 busy", {63'd0, busy}, 64'd0);
        chk("R1 mem_req", {63'd0, mem_req}, 64'd0);
        chk("R1 pc_valid", {63'd0, pc_valid}, 64'd0);
        chk("R1 link_we", {63'd0, link_we}, 64'd0);
    endtask

    task automatic test_plain_jumps();
        run_op(8'd0,  64'h0000_0000_0000_2468, 3'd4, 64'h0000_0000_0000_4000, 0, 0);
        run_op(8'd31, 64'h0000_0000_0000_3000, 3'd2, 64'h0000_0000_0000_4000, 2, 0);
    endtask

    task automatic test_link_jumps();
        run_op(8'd32,  64'h0000_0000_0000_2468, 3'd4, 64'h0000_0000_0000_4000, 1, 0);
        run_op(8'd255, 64'h0000_0010_0000_1000, 3'd2, 64'h0000_0000_8000_0000, 3, 0);
    endtask

    task automatic test_mode_bits();
        run_op(8'd5,  64'h0000_0000_0000_0100, 3'd4, 64'h0000_0000_0000_403F, 0, 0);
        run_op(8'd40, 64'h0000_0000_0000_0200, 3'd2, 64'h1234_5678_9ABC_DEC1, 1, 0);
    endtask

    task automatic test_busy_refusal();
        run_op(8'd7,  64'h0000_0000_0000_0800, 3'd4, 64'h0000_0000_0000_4000, 4, 1);
        run_op(8'd33, 64'h0000_0000_0000_0900, 3'd2, 64'h0000_0000_0000_C000, 3, 1);
    endtask

    initial begin
        rst = 1'b1; req_valid = 0; req_index = 0; req_pc = 0; req_size = 0;
        base_reg = 0; mem_ack = 0; mem_rdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_plain_jumps();
        test_link_jumps();
        test_mode_bits();
        test_busy_refusal();
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                vectors++; misses++;
                $display("FAIL watchdog: actual hung expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule